// File: doc/BRIEF.md
# SPI flash controller register bank

This block is the software-visible register file of a serial flash controller that can serve up to five flash devices. A host reaches it through a word-addressed read/write port carrying 32-bit data. From the stored values it drives one active-low select line per device, a two-bit command-mode qualifier per device, and a per-device write-permission flag. The logic that shifts bytes onto the serial bus reads these qualifiers.

Each per-device control word holds a "hold deselected" bit. While that bit is set, the select line of that device stays high. The configuration word holds one write-permission bit per device, starting at bit 16. An address-width word and an interrupt word are also present:

- The address-width word is only stored and read back.
- The interrupt word is fixed. From reset it reports a transfer-done status and no write changes it.

The locations set aside for transfer, checksum, window and timing functions are not built here. They read as zero and drop writes, and so do control slots beyond the configured device count.

Word index = byte offset / 4. The configuration word is at index 0, address width at 1, interrupt at 2, and device n control at 4+n. The parameter `NUM_CS` (default 3) gives the device count and is clamped to 5. The parameter `REG_WORDS` (default 40) gives the size of the register array.

Top module: `spi_flash_regbank`

## Requirements
- R1: After reset:
  - `cs_no` is all ones, and `mode_o`, `wr_en_o`, `rdata_o` and `err_o` are zero.
  - The configuration and address-width words read 0.
  - Every implemented control word reads 0x0000_0004.
  - The interrupt word reads 0x0000_0800.
- R2: A write to index 0 stores all 32 bits and reads back unchanged. `wr_en_o[n]` equals configuration bit 16+n from the cycle after the write. Bit 31 is stored but affects no output.
- R3: A write to index 4+n (n < NUM_CS) sets `cs_no[n]` to written bit 2 (1 = deselected, 0 = selected) from the cycle after the write. Without such a write, `cs_no[n]` holds.
- R4: The control word for device n is stored in full and reads back, command byte in bits 23:16 included. `mode_o[2n+1:2n]` equals its bits 1:0 from the cycle after the write. The encodings are 0 = normal read, 1 = fast read, 2 = write, 3 = user.
- R5: A write to index 1 stores all 32 bits (bit n = 32-bit addressing for device n) and reads back. It changes no output.
- R6: Index 2 always reads 0x0000_0800 and ignores writes.
- R7: Any other index below REG_WORDS reads 0 and ignores writes without raising `err_o`. This includes indices 4+n for n >= NUM_CS, and 3, 9..39.
- R8: An access, read or write, with index >= REG_WORDS makes `err_o` high for exactly the next cycle. A read there returns 0.
- R9: `rdata_o` takes the addressed value in the cycle after a read request and holds it until the next read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Word index of the access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| err_o | output | 1 | One-cycle out-of-range flag |
| cs_no | output | NUM_CS | Active-low device selects |
| mode_o | output | 2*NUM_CS | Command mode per device, two bits each |
| wr_en_o | output | NUM_CS | Write permission per device |

## Verification
The properties assume that `req_i`, `we_i`, `addr_i` and `wdata_i` are known and steady at each rising clock edge. They also assume that the host issues at most one access per cycle. The bench drives all inputs on the falling edge and returns `req_i` to zero or to a fresh access each cycle, so every edge samples settled values. Random addresses cover the implemented words, the unimplemented gaps, the unused control slots and indices past the array. This keeps every antecedent reachable without ever leaving an input undefined.

// File: rtl/spi_regbank_pkg.sv
package spi_regbank_pkg;

  localparam int unsigned DATA_W     = 32;
  localparam int unsigned MAX_CS     = 5;
  localparam int unsigned IDX_CONF   = 0;
  localparam int unsigned IDX_ADRW   = 1;
  localparam int unsigned IDX_INTR   = 2;
  localparam int unsigned IDX_CTRL0  = 4;
  localparam int unsigned BIT_HOLD   = 2;
  localparam int unsigned BIT_WREN0  = 16;
  localparam int unsigned SLOT_IDX_W = 3;

  localparam logic [DATA_W-1:0] INTR_VALUE = 32'h0000_0800;
  localparam logic [DATA_W-1:0] CTRL_RESET = 32'h0000_0004;

  typedef enum logic [1:0] {
    MODE_READ  = 2'd0,
    MODE_FAST  = 2'd1,
    MODE_WRITE = 2'd2,
    MODE_USER  = 2'd3
  } cmd_mode_e;

  typedef struct packed {
    logic conf;
    logic adrw;
    logic intr;
    logic ctrl;
    logic oob;
  } reg_sel_t;

endpackage

// File: rtl/spi_regbank_decode.sv
module spi_regbank_decode
  import spi_regbank_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned REG_WORDS = 40,
  parameter int unsigned CS_N      = 3
) (
  input  logic [ADDR_W-1:0]     addr_i,
  output reg_sel_t              sel_o,
  output logic [SLOT_IDX_W-1:0] slot_o
);

  logic [31:0] idx;
  logic [31:0] rel;

  assign idx = 32'(addr_i);
  assign rel = idx - IDX_CTRL0;

  always_comb begin
    sel_o  = '0;
    slot_o = '0;
    if (idx >= REG_WORDS) begin
      sel_o.oob = 1'b1;
    end else if (idx == IDX_CONF) begin
      sel_o.conf = 1'b1;
    end else if (idx == IDX_ADRW) begin
      sel_o.adrw = 1'b1;
    end else if (idx == IDX_INTR) begin
      sel_o.intr = 1'b1;
    end else if (idx >= IDX_CTRL0 && rel < CS_N) begin
      sel_o.ctrl = 1'b1;
      slot_o     = rel[SLOT_IDX_W-1:0];
    end
  end

endmodule

// File: rtl/spi_regbank_cs_slot.sv
module spi_regbank_cs_slot
  import spi_regbank_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] value_o,
  output logic              hold_o,
  output cmd_mode_e         mode_o
);

  logic [DATA_W-1:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_RESET;
    end else if (we_i) begin
      ctrl_q <= wdata_i;
    end
  end

  assign value_o = ctrl_q;
  assign hold_o  = ctrl_q[BIT_HOLD];
  assign mode_o  = cmd_mode_e'(ctrl_q[1:0]);

endmodule

// File: rtl/spi_flash_regbank.sv
module spi_flash_regbank
  import spi_regbank_pkg::*;
#(
  parameter int unsigned NUM_CS    = 3,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned REG_WORDS = 40
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic [DATA_W-1:0]     rdata_o,
  output logic                  err_o,
  output logic [NUM_CS-1:0]     cs_no,
  output logic [2*NUM_CS-1:0]   mode_o,
  output logic [NUM_CS-1:0]     wr_en_o
);

  localparam int unsigned CS_N = (NUM_CS > MAX_CS) ? MAX_CS : NUM_CS;

  reg_sel_t              sel;
  logic [SLOT_IDX_W-1:0] slot;
  logic                  wr_acc;
  logic                  rd_acc;
  logic [DATA_W-1:0]     conf_q;
  logic [DATA_W-1:0]     adrw_q;
  logic [DATA_W-1:0]     slot_val [NUM_CS];
  logic [DATA_W-1:0]     rd_val;

  assign wr_acc = req_i & we_i;
  assign rd_acc = req_i & ~we_i;

  spi_regbank_decode #(
    .ADDR_W    (ADDR_W),
    .REG_WORDS (REG_WORDS),
    .CS_N      (CS_N)
  ) u_decode (
    .addr_i (addr_i),
    .sel_o  (sel),
    .slot_o (slot)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      conf_q <= '0;
      adrw_q <= '0;
    end else begin
      if (wr_acc && sel.conf) conf_q <= wdata_i;
      if (wr_acc && sel.adrw) adrw_q <= wdata_i;
    end
  end

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    if (g < CS_N) begin : g_impl
      cmd_mode_e m;
      logic      hold;
      spi_regbank_cs_slot u_slot (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (wr_acc && sel.ctrl && (slot == SLOT_IDX_W'(g))),
        .wdata_i (wdata_i),
        .value_o (slot_val[g]),
        .hold_o  (hold),
        .mode_o  (m)
      );
      assign cs_no[g]       = hold;
      assign mode_o[2*g+:2] = m;
      assign wr_en_o[g]     = conf_q[BIT_WREN0+g];
    end else begin : g_none
      assign slot_val[g]    = '0;
      assign cs_no[g]       = 1'b1;
      assign mode_o[2*g+:2] = MODE_READ;
      assign wr_en_o[g]     = 1'b0;
    end
  end

  always_comb begin
    rd_val = '0;
    if (sel.conf) rd_val = conf_q;
    if (sel.adrw) rd_val = adrw_q;
    if (sel.intr) rd_val = INTR_VALUE;
    if (sel.ctrl) begin
      for (int i = 0; i < NUM_CS; i++) begin
        if (slot == SLOT_IDX_W'(i)) rd_val = slot_val[i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      err_o   <= 1'b0;
    end else begin
      if (rd_acc) rdata_o <= rd_val;
      err_o <= req_i & sel.oob;
    end
  end

endmodule

// File: rtl/spi_flash_regbank_chk.sv
module spi_flash_regbank_chk
  import spi_regbank_pkg::*;
#(
  parameter int unsigned NUM_CS    = 3,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned REG_WORDS = 40
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_i,
  input logic                we_i,
  input logic [ADDR_W-1:0]   addr_i,
  input logic [DATA_W-1:0]   wdata_i,
  input logic [DATA_W-1:0]   rdata_o,
  input logic                err_o,
  input logic [NUM_CS-1:0]   cs_no,
  input logic [2*NUM_CS-1:0] mode_o,
  input logic [NUM_CS-1:0]   wr_en_o
);

  localparam int unsigned CS_N = (NUM_CS > MAX_CS) ? MAX_CS : NUM_CS;

  logic out_of_range;
  assign out_of_range = (32'(addr_i) >= REG_WORDS);

  for (genvar g = 0; g < CS_N; g++) begin : g_p
    p_hold_follows_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i && we_i && addr_i == ADDR_W'(IDX_CTRL0 + g)) |=> (cs_no[g] == $past(wdata_i[BIT_HOLD])));
    p_hold_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(req_i && we_i && addr_i == ADDR_W'(IDX_CTRL0 + g)) |=> $stable(cs_no[g]));
    p_mode_follows_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i && we_i && addr_i == ADDR_W'(IDX_CTRL0 + g)) |=> (mode_o[2*g+:2] == $past(wdata_i[1:0])));
    p_wren_follows_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i && we_i && addr_i == ADDR_W'(IDX_CONF)) |=> (wr_en_o[g] == $past(wdata_i[BIT_WREN0+g])));
  end

  p_wren_stable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i && addr_i == ADDR_W'(IDX_CONF)) |=> $stable(wr_en_o));
  p_err_raise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && out_of_range) |=> err_o);
  p_err_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && out_of_range) |=> !err_o);
  p_oob_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && out_of_range) |=> (rdata_o == '0));
  p_intr_fixed_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == ADDR_W'(IDX_INTR)) |=> (rdata_o == INTR_VALUE));
  p_gap_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == ADDR_W'(3)) |=> (rdata_o == '0));
  p_rdata_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> $stable(rdata_o));

endmodule

bind spi_flash_regbank spi_flash_regbank_chk #(
  .NUM_CS    (NUM_CS),
  .ADDR_W    (ADDR_W),
  .REG_WORDS (REG_WORDS)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .err_o   (err_o),
  .cs_no   (cs_no),
  .mode_o  (mode_o),
  .wr_en_o (wr_en_o)
);

// File: tb/spi_flash_regbank_tb.sv
`timescale 1ns/1ps
module spi_flash_regbank_tb;

  localparam int NCS   = 3;
  localparam int AW    = 8;
  localparam int WORDS = 40;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            req_i = 1'b0;
  logic            we_i = 1'b0;
  logic [AW-1:0]   addr_i = '0;
  logic [31:0]     wdata_i = '0;
  logic [31:0]     rdata_o;
  logic            err_o;
  logic [NCS-1:0]  cs_no;
  logic [2*NCS-1:0] mode_o;
  logic [NCS-1:0]  wr_en_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference state
  logic [31:0] m_conf, m_adrw, m_rdata;
  logic [31:0] m_ctrl [NCS];
  logic        m_err;

  always #2 clk_i = ~clk_i;

  spi_flash_regbank #(.NUM_CS(NCS), .ADDR_W(AW), .REG_WORDS(WORDS)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .err_o(err_o), .cs_no(cs_no),
    .mode_o(mode_o), .wr_en_o(wr_en_o)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] m_read(int a);
    if (a >= WORDS) return 32'h0;
    if (a == 0) return m_conf;
    if (a == 1) return m_adrw;
    if (a == 2) return 32'h0000_0800;
    if (a >= 4 && a < 4 + NCS) return m_ctrl[a-4];
    return 32'h0;
  endfunction

  task automatic m_reset();
    m_conf = '0; m_adrw = '0; m_rdata = '0; m_err = 1'b0;
    for (int i = 0; i < NCS; i++) m_ctrl[i] = 32'h4;
  endtask

  task automatic compare_all();
    logic [NCS-1:0]   e_cs;
    logic [2*NCS-1:0] e_md;
    logic [NCS-1:0]   e_we;
    for (int i = 0; i < NCS; i++) begin
      e_cs[i]       = m_ctrl[i][2];
      e_md[2*i+:2]  = m_ctrl[i][1:0];
      e_we[i]       = m_conf[16+i];
    end
    check("R3 cs_no", 32'(cs_no), 32'(e_cs));
    check("R4 mode_o", 32'(mode_o), 32'(e_md));
    check("R2 wr_en_o", 32'(wr_en_o), 32'(e_we));
    check("R9 rdata_o", rdata_o, m_rdata);
    check("R8 err_o", 32'(err_o), 32'(m_err));
  endtask

  task automatic step(bit rq, bit w, int a, logic [31:0] d);
    @(negedge clk_i);
    compare_all();
    req_i = rq; we_i = w; addr_i = AW'(a); wdata_i = d;
    @(posedge clk_i);
    #1;
    m_err = rq && (a >= WORDS);
    if (rq && !w) m_rdata = m_read(a);
    if (rq && w && a < WORDS) begin
      if (a == 0) m_conf = d;
      else if (a == 1) m_adrw = d;
      else if (a >= 4 && a < 4 + NCS) m_ctrl[a-4] = d;
    end
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(int a, logic [31:0] exp, string tag);
    step(1'b1, 1'b0, a, 32'h0);
    check(tag, rdata_o, exp);
  endtask

  initial begin
    #800000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    m_reset();
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check("R1 cs_no", 32'(cs_no), 32'h7);
    check("R1 wr_en_o", 32'(wr_en_o), 32'h0);
    check("R1 mode_o", 32'(mode_o), 32'h0);
    check("R1 rdata_o", rdata_o, 32'h0);
    check("R1 err_o", 32'(err_o), 32'h0);
    rst_ni = 1'b1;
    rd(0, 32'h0, "R1 conf");
    rd(1, 32'h0, "R1 adrw");
    rd(4, 32'h4, "R1 ctrl0");
    rd(6, 32'h4, "R1 ctrl2");
    rd(2, 32'h800, "R1 intr");

    // R2 configuration
    step(1'b1, 1'b1, 0, 32'h8002_0000);
    check("R2 wr_en after write", 32'(wr_en_o), 32'h2);
    rd(0, 32'h8002_0000, "R2 conf readback");

    // R3 / R4 control words
    step(1'b1, 1'b1, 4, 32'h00AB_0001);
    check("R3 cs0 selected", 32'(cs_no), 32'h6);
    check("R4 mode0 fast", 32'(mode_o[1:0]), 32'h1);
    step(1'b1, 1'b1, 5, 32'h0000_0007);
    step(1'b1, 1'b1, 6, 32'h0012_0002);
    check("R3 cs pattern", 32'(cs_no), 32'h2);
    check("R4 modes", 32'(mode_o), 32'h2D);
    rd(4, 32'h00AB_0001, "R4 cmd byte readback");
    step(1'b1, 1'b1, 4, 32'h0000_0004);
    check("R3 cs0 released", 32'(cs_no), 32'h3);

    // R5 address-width word
    step(1'b1, 1'b1, 1, 32'h0000_001F);
    check("R5 outputs unchanged", {26'h0, cs_no, wr_en_o}, {26'h0, 3'h3, 3'h2});
    rd(1, 32'h1F, "R5 adrw readback");

    // R6 interrupt word
    step(1'b1, 1'b1, 2, 32'hFFFF_FFFF);
    rd(2, 32'h800, "R6 intr after write");

    // R7 unimplemented locations
    step(1'b1, 1'b1, 3, 32'hFFFF_FFFF);
    step(1'b1, 1'b1, 7, 32'hFFFF_FFFF);
    step(1'b1, 1'b1, 8, 32'hFFFF_FFFF);
    step(1'b1, 1'b1, 37, 32'hFFFF_FFFF);
    check("R7 no error on gap", 32'(err_o), 32'h0);
    check("R7 outputs unchanged", 32'(cs_no), 32'h3);
    rd(3, 32'h0, "R7 gap 3");
    rd(7, 32'h0, "R7 unused slot 3");
    rd(8, 32'h0, "R7 unused slot 4");
    rd(37, 32'h0, "R7 gap 37");

    // R8 out-of-range
    rd(0, 32'h8002_0000, "R9 preload");
    step(1'b1, 1'b0, 40, 32'h0);
    check("R8 err raised", 32'(err_o), 32'h1);
    check("R8 read zero", rdata_o, 32'h0);
    step(1'b0, 1'b0, 0, 32'h0);
    check("R8 err one cycle", 32'(err_o), 32'h0);
    rd(1, 32'h1F, "R9 preload2");
    step(1'b1, 1'b1, 255, 32'h1234_5678);
    check("R8 err on write", 32'(err_o), 32'h1);
    check("R9 hold over write", rdata_o, 32'h1F);

    // R9 hold
    repeat (4) step(1'b0, 1'b0, 0, 32'h0);
    check("R9 hold idle", rdata_o, 32'h1F);

    // mixed traffic compared against the reference every cycle
    for (int n = 0; n < 4000; n++) begin
      int a;
      a = (n % 50 == 0) ? int'($urandom_range(40, 255)) : int'($urandom_range(0, 47));
      step(bit'($urandom_range(0, 3) != 0), bit'($urandom_range(0, 1)), a, $urandom);
    end
    step(1'b0, 1'b0, 0, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule